// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the raster timing for a display panel or a TV-style output from a small set of timing values held in configuration registers. It runs in the pixel clock domain. It counts pixels within a line and lines within a field. From those counts it drives horizontal and vertical sync, a data-enable window and an early line-start pulse. An upstream pixel fetcher uses that pulse to begin reading ahead of the first visible line.

The horizontal and vertical totals, back porches, sync widths, active sizes, sync inversions and the interlace flag arrive as plain register values. A shadow copy takes them in while the block is disabled and again at each frame boundary, so a register write during a frame never changes that frame. A build-time mode picks one of two variants. The panel variant counts whole lines. The TV variant counts the vertical axis in half lines and supports interlaced fields, where the second field is offset by half a line. A separate tristate request controls whether the output pads drive.

Top module: `raster_timing_gen`

## Requirements
- R1: While reset is asserted, `pad_oe` is 0, `h_pos`, `v_pos`, `de`, `field` and `line_pre` are 0, and the sync outputs sit at the level given by cleared inversion bits (0).
- R2: While enabled, `h_pos` counts up once per clock from 0 to `ht-1` and then returns to 0.
- R3: `hsync` is active for the first `hsw` clocks of each line (`h_pos < hsw`).
- R4: `de` is 1 only when `h_pos` lies in [`hbp`, `hbp+ha`) and the current line index lies in [`vbp`, `vbp+H`), where H is `va`, or `va/2` for an interlaced field.
- R5: In the panel variant, `v_pos` is the line index 0..`vt-1`, it advances when `h_pos` wraps, and `vsync` is active while `v_pos < vsw`.
- R6: Setting `hs_inv` or `vs_inv` inverts only its own sync output (bit = 1 gives active-low). With both bits cleared, both syncs are active-high.
- R7: `pad_oe` equals the inverse of `tri_req` as sampled on the previous clock edge.
- R8: While `en` is 0, `de` and `line_pre` are 0 and the syncs are inactive. On the next clock edge `h_pos` and `v_pos` return to 0, and counting restarts from 0,0 when `en` rises.
- R9: All timing inputs are captured every cycle while disabled. While running they are captured only on the clock edge that ends a frame, so a mid-frame change first affects the following frame.
- R10: `line_pre` pulses for one clock at `h_pos == 0` of line `vbp - D`, or of line 0 if `D >= vbp`. D is the vertical blanking in lines, halved when interlaced, reduced by 2 (not below 0) in the TV variant, and limited to `DLY_CAP` (30).
- R11: In the TV variant, `vt` is given in half lines. `v_pos` advances at `h_pos == 0` and at `h_pos == ht/2`, `vsync` covers the first `2*vsw` half lines, and the line index is `v_pos` at line start divided by 2.
- R12: In the TV variant with `ilace` set, a field lasts `vt` half lines and `field` toggles at each field end, so the second field starts half a line late. A frame is two fields.
- R13: In the panel variant `ilace` has no effect: `field` stays 0 and the timing is progressive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Timing generator enable |
| tri_req | input | 1 | 1 = release output pads |
| ht | input | HW | Horizontal total in clocks |
| ha | input | HW | Active width |
| hbp | input | HW | Clocks from sync start to first active pixel |
| hsw | input | HW | Hsync width |
| vt | input | VW | Vertical total (lines; half lines in TV variant) |
| va | input | VW | Active height (frame lines) |
| vbp | input | VW | Lines from sync start to first active line |
| vsw | input | VW | Vsync width in lines |
| hs_inv | input | 1 | Invert hsync |
| vs_inv | input | 1 | Invert vsync |
| ilace | input | 1 | Interlace enable (TV variant) |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| h_pos | output | HW | Pixel counter |
| v_pos | output | VW | Line or half-line counter within field |
| field | output | 1 | Current field (1 = second) |
| line_pre | output | 1 | Early line-start pulse for fetcher |
| pad_oe | output | 1 | Pads driven when 1 |

## Verification
Some properties are checked on every cycle: the pixel counter's single-step advance, the exclusion of data enable from the hsync pulse, the idle state while disabled, the one-cycle lag of pad enable behind the tristate request, and a field flag that stays low without interlace. Other behaviour only shows over whole frames in the bench sweeps. That includes the placement of the active window, the half-line offset of the second interlaced field, where the early pulse lands once the delay is limited, and the frame-boundary capture of new settings.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
   typedef enum logic {
      TM_PANEL = 1'b0,
      TM_TV    = 1'b1
   } tmode_e;

   localparam int unsigned RTG_DLY_CAP = 30;
endpackage

// File: rtl/rtg_shadow.sv
module rtg_shadow
   import rtg_pkg::*;
#(
   parameter int unsigned HW      = 11,
   parameter int unsigned VW      = 11,
   parameter tmode_e      MODE    = TM_PANEL,
   parameter int unsigned DLY_CAP = RTG_DLY_CAP
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [HW-1:0] ht_i,
   input  logic [HW-1:0] ha_i,
   input  logic [HW-1:0] hbp_i,
   input  logic [HW-1:0] hsw_i,
   input  logic [VW-1:0] vt_i,
   input  logic [VW-1:0] va_i,
   input  logic [VW-1:0] vbp_i,
   input  logic [VW-1:0] vsw_i,
   input  logic          hinv_i,
   input  logic          vinv_i,
   input  logic          il_i,
   output logic [HW-1:0] ht,
   output logic [HW-1:0] ha,
   output logic [HW-1:0] hbp,
   output logic [HW-1:0] hsw,
   output logic [VW-1:0] vt,
   output logic [VW-1:0] vbp,
   output logic [VW-1:0] vsw,
   output logic          hinv,
   output logic          vinv,
   output logic          il,
   output logic [VW-1:0] act_h,
   output logic [VW-1:0] pre_ln
);
   localparam logic [VW-1:0] CAP = VW'(DLY_CAP);

   logic [VW-1:0] va;
   logic [VW-1:0] blank;
   logic [VW-1:0] dly_a;
   logic [VW-1:0] dly;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ht <= '0; ha <= '0; hbp <= '0; hsw <= '0;
         vt <= '0; va <= '0; vbp <= '0; vsw <= '0;
         hinv <= 1'b0; vinv <= 1'b0; il <= 1'b0;
      end else if (load) begin
         ht   <= ht_i;  ha  <= ha_i;  hbp <= hbp_i; hsw <= hsw_i;
         vt   <= vt_i;  va  <= va_i;  vbp <= vbp_i; vsw <= vsw_i;
         hinv <= hinv_i;
         vinv <= vinv_i;
         il   <= (MODE == TM_TV) ? il_i : 1'b0;
      end
   end

   // Vertical blanking in whole lines, then the mode-specific adjustment.
   generate
      if (MODE == TM_TV) begin : g_tv
         always_comb begin
            if (il) blank = (vt - va) >> 1;
            else    blank = (vt >> 1) - va;
            dly_a = (blank > VW'(2)) ? blank - VW'(2) : '0;
         end
      end else begin : g_panel
         assign blank = vt - va;
         assign dly_a = blank;
      end
   endgenerate

   assign dly    = (dly_a > CAP) ? CAP : dly_a;
   assign pre_ln = (vbp > dly) ? vbp - dly : '0;
   assign act_h  = il ? (va >> 1) : va;
endmodule

// File: rtl/rtg_count.sv
module rtg_count
   import rtg_pkg::*;
#(
   parameter int unsigned HW   = 11,
   parameter int unsigned VW   = 11,
   parameter tmode_e      MODE = TM_PANEL
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic [HW-1:0] ht,
   input  logic [VW-1:0] vt,
   input  logic          il,
   output logic [HW-1:0] hc,
   output logic [VW-1:0] vc,
   output logic [VW-1:0] vls,
   output logic          field,
   output logic          frame_wrap
);
   logic          line_end;
   logic          half;
   logic          step;
   logic          vwrap;
   logic [VW-1:0] vc_nx;

   assign line_end = (hc == ht - 1'b1);

   generate
      if (MODE == TM_TV) begin : g_half
         assign half = (hc == (ht >> 1) - 1'b1);
      end else begin : g_whole
         assign half = 1'b0;
      end
   endgenerate

   assign step       = en & (line_end | half);
   assign vwrap      = step & (vc == vt - 1'b1);
   assign frame_wrap = vwrap & line_end;

   always_comb begin
      if (vwrap)     vc_nx = '0;
      else if (step) vc_nx = vc + 1'b1;
      else           vc_nx = vc;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hc <= '0; vc <= '0; vls <= '0; field <= 1'b0;
      end else if (!en) begin
         hc <= '0; vc <= '0; vls <= '0; field <= 1'b0;
      end else begin
         hc <= line_end ? '0 : hc + 1'b1;
         vc <= vc_nx;
         if (line_end) vls <= vc_nx;
         if (vwrap)    field <= il ? ~field : 1'b0;
      end
   end
endmodule

// File: rtl/rtg_pins.sv
module rtg_pins
   import rtg_pkg::*;
#(
   parameter int unsigned HW   = 11,
   parameter int unsigned VW   = 11,
   parameter tmode_e      MODE = TM_PANEL
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          tri_req,
   input  logic [HW-1:0] hc,
   input  logic [VW-1:0] vc,
   input  logic [VW-1:0] vls,
   input  logic [HW-1:0] ha,
   input  logic [HW-1:0] hbp,
   input  logic [HW-1:0] hsw,
   input  logic [VW-1:0] vbp,
   input  logic [VW-1:0] vsw,
   input  logic [VW-1:0] act_h,
   input  logic [VW-1:0] pre_ln,
   input  logic          hinv,
   input  logic          vinv,
   output logic          hsync,
   output logic          vsync,
   output logic          de,
   output logic          line_pre,
   output logic          pad_oe
);
   logic [VW-1:0] li;
   logic [VW:0]   vsw_steps;
   logic          h_in;
   logic          v_in;

   generate
      if (MODE == TM_TV) begin : g_tv
         assign li        = vls >> 1;
         assign vsw_steps = {vsw, 1'b0};
      end else begin : g_panel
         assign li        = vls;
         assign vsw_steps = {1'b0, vsw};
      end
   endgenerate

   assign h_in = ({1'b0, hc} >= {1'b0, hbp}) &&
                 ({1'b0, hc} <  ({1'b0, hbp} + {1'b0, ha}));
   assign v_in = ({1'b0, li} >= {1'b0, vbp}) &&
                 ({1'b0, li} <  ({1'b0, vbp} + {1'b0, act_h}));

   assign hsync    = (en & (hc < hsw)) ^ hinv;
   assign vsync    = (en & ({1'b0, vc} < vsw_steps)) ^ vinv;
   assign de       = en & h_in & v_in;
   assign line_pre = en & (hc == '0) & (li == pre_ln);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pad_oe <= 1'b0;
      else        pad_oe <= ~tri_req;
   end
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
   import rtg_pkg::*;
#(
   parameter int unsigned HW      = 11,
   parameter int unsigned VW      = 11,
   parameter tmode_e      MODE    = TM_PANEL,
   parameter int unsigned DLY_CAP = RTG_DLY_CAP
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          tri_req,
   input  logic [HW-1:0] ht,
   input  logic [HW-1:0] ha,
   input  logic [HW-1:0] hbp,
   input  logic [HW-1:0] hsw,
   input  logic [VW-1:0] vt,
   input  logic [VW-1:0] va,
   input  logic [VW-1:0] vbp,
   input  logic [VW-1:0] vsw,
   input  logic          hs_inv,
   input  logic          vs_inv,
   input  logic          ilace,
   output logic          hsync,
   output logic          vsync,
   output logic          de,
   output logic [HW-1:0] h_pos,
   output logic [VW-1:0] v_pos,
   output logic          field,
   output logic          line_pre,
   output logic          pad_oe
);
   initial begin
      assert (HW >= 3 && HW <= 16) else $error("HW out of range");
      assert (VW >= 3 && VW <= 16) else $error("VW out of range");
      assert (DLY_CAP < (1 << VW)) else $error("DLY_CAP exceeds VW");
   end

   logic [HW-1:0] s_ht, s_ha, s_hbp, s_hsw;
   logic [VW-1:0] s_vt, s_vbp, s_vsw, s_act_h, s_pre;
   logic          s_hinv, s_vinv, s_il;
   logic [VW-1:0] vls;
   logic          frame_wrap;

   rtg_shadow #(.HW(HW), .VW(VW), .MODE(MODE), .DLY_CAP(DLY_CAP)) u_shadow (
      .clk(clk), .rst_n(rst_n), .load(~en | frame_wrap),
      .ht_i(ht), .ha_i(ha), .hbp_i(hbp), .hsw_i(hsw),
      .vt_i(vt), .va_i(va), .vbp_i(vbp), .vsw_i(vsw),
      .hinv_i(hs_inv), .vinv_i(vs_inv), .il_i(ilace),
      .ht(s_ht), .ha(s_ha), .hbp(s_hbp), .hsw(s_hsw),
      .vt(s_vt), .vbp(s_vbp), .vsw(s_vsw),
      .hinv(s_hinv), .vinv(s_vinv), .il(s_il),
      .act_h(s_act_h), .pre_ln(s_pre)
   );

   rtg_count #(.HW(HW), .VW(VW), .MODE(MODE)) u_count (
      .clk(clk), .rst_n(rst_n), .en(en),
      .ht(s_ht), .vt(s_vt), .il(s_il),
      .hc(h_pos), .vc(v_pos), .vls(vls), .field(field),
      .frame_wrap(frame_wrap)
   );

   rtg_pins #(.HW(HW), .VW(VW), .MODE(MODE)) u_pins (
      .clk(clk), .rst_n(rst_n), .en(en), .tri_req(tri_req),
      .hc(h_pos), .vc(v_pos), .vls(vls),
      .ha(s_ha), .hbp(s_hbp), .hsw(s_hsw),
      .vbp(s_vbp), .vsw(s_vsw), .act_h(s_act_h), .pre_ln(s_pre),
      .hinv(s_hinv), .vinv(s_vinv),
      .hsync(hsync), .vsync(vsync), .de(de), .line_pre(line_pre),
      .pad_oe(pad_oe)
   );
endmodule

// File: rtl/rtg_chk.sv
module rtg_chk #(
   parameter int unsigned HW = 11
) (
   input logic          clk,
   input logic          rst_n,
   input logic          en,
   input logic          tri_req,
   input logic          hsync,
   input logic          hinv,
   input logic          de,
   input logic          pad_oe,
   input logic          field,
   input logic          il,
   input logic [HW-1:0] h_pos,
   input logic [HW-1:0] ht
);
   AST_HPOS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (en && h_pos != ht - 1'b1) |=> (h_pos == $past(h_pos) + 1'b1)); // R2

   AST_DE_OUTSIDE_HSYNC: assert property (@(posedge clk) disable iff (!rst_n)
      de |-> ((hsync ^ hinv) == 1'b0)); // R4

   AST_IDLE_DE: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> !de); // R8

   AST_IDLE_POS: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (h_pos == '0)); // R8

   AST_PAD_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (pad_oe == !$past(tri_req))); // R7

   AST_FIELD_PROG: assert property (@(posedge clk) disable iff (!rst_n)
      !il |=> !field); // R13
endmodule

bind raster_timing_gen rtg_chk #(.HW(HW)) u_chk (
   .clk(clk), .rst_n(rst_n), .en(en), .tri_req(tri_req),
   .hsync(hsync), .hinv(s_hinv), .de(de), .pad_oe(pad_oe),
   .field(field), .il(s_il), .h_pos(h_pos), .ht(s_ht)
);

// File: tb/raster_timing_gen_tb.sv
module raster_timing_gen_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic        c_en[2], c_tri[2], c_hinv[2], c_vinv[2], c_il[2];
   logic [10:0] c_ht[2], c_ha[2], c_hbp[2], c_hsw[2];
   logic [10:0] c_vt[2], c_va[2], c_vbp[2], c_vsw[2];
   logic        o_hs[2], o_vs[2], o_de[2], o_fld[2], o_pre[2], o_oe[2];
   logic [10:0] o_hp[2], o_vp[2];

   int m_ht[2], m_ha[2], m_hbp[2], m_hs[2], m_vt[2], m_va[2], m_vbp[2], m_vs[2];
   int m_hi[2], m_vi[2], m_il[2];
   int p_ht[2], p_ha[2], p_hbp[2], p_hs[2], p_vt[2], p_va[2], p_vbp[2], p_vs[2];
   int p_hi[2], p_vi[2], p_il[2];
   int total = 0;
   int bad = 0;
   int t_now = 0;

   raster_timing_gen u_dut (
      .clk(clk), .rst_n(rst_n), .en(c_en[0]), .tri_req(c_tri[0]),
      .ht(c_ht[0]), .ha(c_ha[0]), .hbp(c_hbp[0]), .hsw(c_hsw[0]),
      .vt(c_vt[0]), .va(c_va[0]), .vbp(c_vbp[0]), .vsw(c_vsw[0]),
      .hs_inv(c_hinv[0]), .vs_inv(c_vinv[0]), .ilace(c_il[0]),
      .hsync(o_hs[0]), .vsync(o_vs[0]), .de(o_de[0]), .h_pos(o_hp[0]),
      .v_pos(o_vp[0]), .field(o_fld[0]), .line_pre(o_pre[0]), .pad_oe(o_oe[0])
   );

   raster_timing_gen #(.MODE(rtg_pkg::TM_TV)) u_dut_tv (
      .clk(clk), .rst_n(rst_n), .en(c_en[1]), .tri_req(c_tri[1]),
      .ht(c_ht[1]), .ha(c_ha[1]), .hbp(c_hbp[1]), .hsw(c_hsw[1]),
      .vt(c_vt[1]), .va(c_va[1]), .vbp(c_vbp[1]), .vsw(c_vsw[1]),
      .hs_inv(c_hinv[1]), .vs_inv(c_vinv[1]), .ilace(c_il[1]),
      .hsync(o_hs[1]), .vsync(o_vs[1]), .de(o_de[1]), .h_pos(o_hp[1]),
      .v_pos(o_vp[1]), .field(o_fld[1]), .line_pre(o_pre[1]), .pad_oe(o_oe[1])
   );

   task automatic chk(input bit ok, input string tag, input string scn,
                      input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s [%s] t=%0d actual=%0d expected=%0d", tag, scn, t_now, act, exp);
      end
   endtask

   task automatic set_cfg(input int d, input bit now, input int ht, input int ha,
                          input int hbp, input int hs, input int vt, input int va,
                          input int vbp, input int vs, input int hi, input int vi,
                          input int il);
      c_ht[d] = 11'(ht);  c_ha[d] = 11'(ha);  c_hbp[d] = 11'(hbp); c_hsw[d] = 11'(hs);
      c_vt[d] = 11'(vt);  c_va[d] = 11'(va);  c_vbp[d] = 11'(vbp); c_vsw[d] = 11'(vs);
      c_hinv[d] = hi[0]; c_vinv[d] = vi[0]; c_il[d] = il[0];
      p_ht[d] = ht; p_ha[d] = ha; p_hbp[d] = hbp; p_hs[d] = hs;
      p_vt[d] = vt; p_va[d] = va; p_vbp[d] = vbp; p_vs[d] = vs;
      p_hi[d] = hi; p_vi[d] = vi; p_il[d] = il;
      if (now) begin
         m_ht[d] = ht; m_ha[d] = ha; m_hbp[d] = hbp; m_hs[d] = hs;
         m_vt[d] = vt; m_va[d] = va; m_vbp[d] = vbp; m_vs[d] = vs;
         m_hi[d] = hi; m_vi[d] = vi; m_il[d] = il;
      end
   endtask

   task automatic adopt(input int d);
      m_ht[d] = p_ht[d]; m_ha[d] = p_ha[d]; m_hbp[d] = p_hbp[d]; m_hs[d] = p_hs[d];
      m_vt[d] = p_vt[d]; m_va[d] = p_va[d]; m_vbp[d] = p_vbp[d]; m_vs[d] = p_vs[d];
      m_hi[d] = p_hi[d]; m_vi[d] = p_vi[d]; m_il[d] = p_il[d];
   endtask

   function automatic int frame_len(input int d);
      int unit = (d == 1) ? m_ht[d] / 2 : m_ht[d];
      int il = (d == 1) ? m_il[d] : 0;
      return (il != 0 ? 2 : 1) * m_vt[d] * unit;
   endfunction

   // Expected outputs at cycle t of the frame, from the requirement formulas.
   task automatic check_now(input int d, input string scn);
      int tv, il, unit, scale, s, fld, fs, x, sl, fls, li, ah, blank, dly, pre;
      int e_hs, e_vs, e_de, e_pre;
      tv    = (d == 1) ? 1 : 0;
      il    = tv ? m_il[d] : 0;
      unit  = tv ? m_ht[d] / 2 : m_ht[d];
      scale = tv ? 2 : 1;
      s     = t_now / unit;
      fld   = (il != 0 && s >= m_vt[d]) ? 1 : 0;
      fs    = fld ? s - m_vt[d] : s;
      x     = t_now % m_ht[d];
      sl    = (t_now - x) / unit;
      fls   = (sl >= m_vt[d]) ? sl - m_vt[d] : sl;
      li    = fls / scale;
      ah    = il ? m_va[d] / 2 : m_va[d];
      if (tv) blank = il ? (m_vt[d] - m_va[d]) / 2 : m_vt[d] / 2 - m_va[d];
      else    blank = m_vt[d] - m_va[d];
      dly   = tv ? ((blank > 2) ? blank - 2 : 0) : blank;
      if (dly > 30) dly = 30;
      pre   = (m_vbp[d] > dly) ? m_vbp[d] - dly : 0;
      e_hs  = ((x < m_hs[d]) ? 1 : 0) ^ m_hi[d];
      e_vs  = ((fs < m_vs[d] * scale) ? 1 : 0) ^ m_vi[d];
      e_de  = (x >= m_hbp[d] && x < m_hbp[d] + m_ha[d] &&
               li >= m_vbp[d] && li < m_vbp[d] + ah) ? 1 : 0;
      e_pre = (x == 0 && li == pre) ? 1 : 0;
      chk(int'(o_hp[d]) == x, "R2", scn, int'(o_hp[d]), x);
      chk(int'(o_hs[d]) == e_hs, "R3", scn, int'(o_hs[d]), e_hs);
      chk(int'(o_de[d]) == e_de, "R4", scn, int'(o_de[d]), e_de);
      chk(int'(o_vp[d]) == fs, "R5", scn, int'(o_vp[d]), fs);
      chk(int'(o_vs[d]) == e_vs, "R5", scn, int'(o_vs[d]), e_vs);
      chk(int'(o_pre[d]) == e_pre, "R10", scn, int'(o_pre[d]), e_pre);
      chk(int'(o_fld[d]) == fld, "R12", scn, int'(o_fld[d]), fld);
   endtask

   task automatic run(input int d, input int n, input string scn);
      for (int i = 0; i < n; i++) begin
         #1;
         check_now(d, scn);
         t_now++;
         if (t_now == frame_len(d)) begin
            t_now = 0;
            adopt(d);
         end
         @(negedge clk);
      end
   endtask

   task automatic start(input int d);
      adopt(d);
      t_now = 0;
      c_en[d] = 1'b1;
   endtask

   task automatic stop_and_check(input int d);
      c_en[d] = 1'b0;
      #1;
      chk(o_de[d] == 1'b0, "R8", "idle", int'(o_de[d]), 0);
      chk(o_hs[d] == c_hinv[d], "R8", "idle", int'(o_hs[d]), int'(c_hinv[d]));
      chk(o_pre[d] == 1'b0, "R8", "idle", int'(o_pre[d]), 0);
      @(negedge clk);
      #1;
      chk(o_hp[d] == 11'd0 && o_vp[d] == 11'd0, "R8", "idle",
          int'(o_hp[d]) + int'(o_vp[d]), 0);
      @(negedge clk);
   endtask

   initial begin
      for (int d = 0; d < 2; d++) begin
         c_en[d] = 1'b0;
         c_tri[d] = 1'b1;
         set_cfg(d, 1'b1, 20, 12, 5, 2, 10, 5, 3, 1, 0, 0, 0);
      end
      repeat (3) @(negedge clk);
      for (int d = 0; d < 2; d++) begin
         chk(o_oe[d] == 1'b0, "R1", "reset", int'(o_oe[d]), 0);
         chk(o_hp[d] == 11'd0 && o_vp[d] == 11'd0, "R1", "reset",
             int'(o_hp[d]) + int'(o_vp[d]), 0);
         chk(o_de[d] == 1'b0 && o_fld[d] == 1'b0 && o_pre[d] == 1'b0, "R1", "reset",
             int'(o_de[d]) + int'(o_fld[d]) + int'(o_pre[d]), 0);
         chk(o_hs[d] == 1'b0 && o_vs[d] == 1'b0, "R1", "reset",
             int'(o_hs[d]) + int'(o_vs[d]), 0);
      end
      rst_n = 1'b1;
      @(negedge clk);
      // R7: pad enable follows the tristate request one edge later
      c_tri[0] = 1'b0;
      c_tri[1] = 1'b0;
      #1;
      chk(o_oe[0] == 1'b0, "R7", "pads", int'(o_oe[0]), 0);
      @(negedge clk);
      #1;
      chk(o_oe[0] == 1'b1 && o_oe[1] == 1'b1, "R7", "pads",
          int'(o_oe[0]) + int'(o_oe[1]), 2);
      @(negedge clk);

      // Panel, plain progressive timing, two frames
      start(0);
      run(0, 400, "R2 base");
      // R9: new settings written mid-frame, effective from the next frame
      run(0, 90, "R9");
      set_cfg(0, 1'b0, 16, 8, 6, 3, 12, 6, 4, 2, 0, 0, 0);
      run(0, 110 + 2 * 192, "R9");
      stop_and_check(0);

      // Panel: inverted syncs, delay limited to 30, interlace bit ignored
      set_cfg(0, 1'b1, 8, 4, 3, 1, 50, 4, 40, 2, 1, 1, 1);
      @(negedge clk);
      start(0);
      run(0, 800, "R6 R10 R13");
      stop_and_check(0);

      // TV variant, progressive with half-line vertical count
      set_cfg(1, 1'b1, 12, 6, 4, 2, 20, 6, 3, 1, 0, 0, 0);
      @(negedge clk);
      start(1);
      run(1, 240, "R11");
      stop_and_check(1);

      // TV variant, interlaced, hsync inverted, vsync not
      set_cfg(1, 1'b1, 12, 6, 4, 2, 15, 8, 3, 1, 1, 0, 1);
      @(negedge clk);
      start(1);
      run(1, 360, "R12 R6");
      stop_and_check(1);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule